// File: doc/BRIEF.md
# Trace Signature Redundancy Checker

This block watches the retirement stream of a processor and checks each stretch of retired code against the way that same stretch behaved the last time it ran. Every retiring instruction brings a decode signature, its PC and a flag that marks it as a branch. The block folds the signatures of consecutive instructions into one running trace signature. A trace closes when a branch retires or when the trace reaches its length cap, whichever comes first.

When a trace closes, the block looks up its signature in a small direct-mapped signature store. The store is keyed by the PC of the trace's first instruction. On a hit with a different stored signature, the block raises a one-cycle fault pulse and reports the trace start PC. On a miss it stays silent and installs the new signature. A later hit on that entry can then expose an error in either of the two executions. Protection therefore comes from the repetition that programs already have, without running any instruction twice.

Top module: `trace_sig_checker`

## Requirements
- R1: The trace signature starts at zero for the first instruction of each trace. Each retiring instruction updates it to (previous value rotated left by one bit) XOR (its decode signature). With a zero start, two single-signature traces 1,0 and 0,2 both fold to 2.
- R2: A retiring instruction with `ret_branch` high closes the current trace. The next retiring instruction starts a new trace at its own PC.
- R3: A trace that has reached MAX_LEN (16) instructions without a branch closes on its 16th instruction. The 17th instruction starts a new trace whose start PC is its own PC.
- R4: A closed trace whose store entry is invalid or holds another tag raises no fault, and its signature is installed.
- R5: A closed trace that hits an entry holding an equal signature raises no fault.
- R6: A closed trace that hits an entry holding a different signature drives `fault` high for exactly the one cycle after the closing retirement. In that cycle `fault_pc` equals the trace start PC.
- R7: On a mismatch the entry is overwritten, so a rerun that repeats the new signature raises no fault.
- R8: The store has 64 entries indexed by PC bits [7:2], and bits [31:8] are held as the tag. A trace with the same index but a different tag misses and replaces the entry.
- R9: Reset clears every entry's valid bit and the running trace state, and holds `fault` low.
- R10: Cycles with `ret_valid` low leave the running trace and the store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | One instruction retires this cycle |
| ret_pc | input | 32 | PC of the retiring instruction |
| ret_sig | input | 16 | Decode signature of the retiring instruction |
| ret_branch | input | 1 | Retiring instruction is a branch |
| fault | output | 1 | One-cycle pulse: trace signature disagrees with stored copy |
| fault_pc | output | 32 | Start PC of the trace that raised the fault |

## Verification
Short branch-terminated traces are replayed unchanged, with one signature altered, and then altered again. These runs separate the miss, match, mismatch and overwrite behaviours. A 21-instruction run with no early branch is altered only in its 17th instruction, so the fault appears only if the length cap split the run into a new trace at that PC. Other runs cover an aliasing PC with the same index but a different tag, traces with idle gaps, a pair of signature orders that fold to the same value, back-to-back single-instruction mismatching traces, and a replay after reset. Together they tell apart fold order, index and tag selection, and the clearing done by reset.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [1:0] {
    LK_NONE  = 2'd0,
    LK_MISS  = 2'd1,
    LK_MATCH = 2'd2,
    LK_DIFF  = 2'd3
  } tsc_lookup_e;
endpackage

// File: rtl/tsc_fold.sv
module tsc_fold #(
  parameter int unsigned SIG_W   = 16,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned MAX_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_valid,
  input  logic [PC_W-1:0]  ret_pc,
  input  logic [SIG_W-1:0] ret_sig,
  input  logic             ret_branch,
  output logic             close,
  output logic [PC_W-1:0]  trace_pc,
  output logic [SIG_W-1:0] trace_sig
);
  localparam int unsigned CNT_W = $clog2(MAX_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SIG_W-1:0] run_q, run_d;
  logic [PC_W-1:0]  start_q, start_d;
  logic             first;
  logic [SIG_W-1:0] base;

  always_comb begin
    first     = (cnt_q == '0);
    base      = first ? '0 : run_q;
    trace_sig = {base[SIG_W-2:0], base[SIG_W-1]} ^ ret_sig;
    trace_pc  = first ? ret_pc : start_q;
    close     = ret_valid && (ret_branch || (cnt_q == LAST));
    cnt_d     = close ? '0 : cnt_q + 1'b1;
    run_d     = trace_sig;
    start_d   = trace_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      run_q   <= '0;
      start_q <= '0;
    end else if (ret_valid) begin
      cnt_q   <= cnt_d;
      run_q   <= run_d;
      start_q <= start_d;
    end
  end
endmodule

// File: rtl/tsc_store.sv
module tsc_store
  import tsc_pkg::*;
#(
  parameter int unsigned SIG_W = 16,
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned ALIGN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close,
  input  logic [PC_W-1:0]  trace_pc,
  input  logic [SIG_W-1:0] trace_sig,
  output tsc_lookup_e      outcome
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned TAG_W = PC_W - IDX_W - ALIGN;

  logic [DEPTH-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [SIG_W-1:0] sig_mem [DEPTH];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             hit;

  always_comb begin
    idx = trace_pc[ALIGN +: IDX_W];
    tag = trace_pc[PC_W-1 -: TAG_W];
    hit = valid_q[idx] && (tag_mem[idx] == tag);
    if (!close)                      outcome = LK_NONE;
    else if (!hit)                   outcome = LK_MISS;
    else if (sig_mem[idx] == trace_sig) outcome = LK_MATCH;
    else                             outcome = LK_DIFF;
    valid_d = valid_q;
    if (close) valid_d[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (close) begin
      tag_mem[idx] <= tag;
      sig_mem[idx] <= trace_sig;
    end
  end
endmodule

// File: rtl/trace_sig_checker.sv
module trace_sig_checker
  import tsc_pkg::*;
#(
  parameter int unsigned SIG_W   = 16,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned MAX_LEN = 16,
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned ALIGN   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_valid,
  input  logic [PC_W-1:0]  ret_pc,
  input  logic [SIG_W-1:0] ret_sig,
  input  logic             ret_branch,
  output logic             fault,
  output logic [PC_W-1:0]  fault_pc
);
  logic             close_w;
  logic [PC_W-1:0]  trace_pc_w;
  logic [SIG_W-1:0] trace_sig_w;
  tsc_lookup_e      outcome_w;
  logic             fault_d;
  logic [PC_W-1:0]  fault_pc_d;

  tsc_fold #(.SIG_W(SIG_W), .PC_W(PC_W), .MAX_LEN(MAX_LEN)) u_fold (
    .clk(clk), .rst_n(rst_n),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_sig(ret_sig), .ret_branch(ret_branch),
    .close(close_w), .trace_pc(trace_pc_w), .trace_sig(trace_sig_w)
  );

  tsc_store #(.SIG_W(SIG_W), .PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_store (
    .clk(clk), .rst_n(rst_n),
    .close(close_w), .trace_pc(trace_pc_w), .trace_sig(trace_sig_w),
    .outcome(outcome_w)
  );

  always_comb begin
    fault_d    = (outcome_w == LK_DIFF);
    fault_pc_d = fault_d ? trace_pc_w : fault_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault    <= 1'b0;
      fault_pc <= '0;
    end else begin
      fault    <= fault_d;
      fault_pc <= fault_pc_d;
    end
  end
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned MAX_LEN = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ret_valid,
  input logic            ret_branch,
  input logic            close_w,
  input logic [PC_W-1:0] trace_pc_w,
  input logic            fault,
  input logic [PC_W-1:0] fault_pc
);
  localparam int unsigned N_W = $clog2(MAX_LEN + 1);
  logic [N_W-1:0] n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                n_q <= '0;
    else if (close_w)          n_q <= '0;
    else if (ret_valid)        n_q <= n_q + 1'b1;
  end

  p_branch_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && ret_branch |-> close_w);
  p_len_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && (n_q == N_W'(MAX_LEN - 1)) |-> close_w);
  p_fault_after_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(close_w));
  p_fault_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> fault_pc == $past(trace_pc_w));
  p_idle_no_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |-> !close_w);
endmodule

bind trace_sig_checker tsc_checker #(.PC_W(PC_W), .MAX_LEN(MAX_LEN)) i_tsc_checker (
  .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_branch(ret_branch),
  .close_w(close_w), .trace_pc_w(trace_pc_w), .fault(fault), .fault_pc(fault_pc)
);

// File: tb/test_trace_sig_checker.sv
module test_trace_sig_checker;
  logic        clk;
  logic        rst_n;
  logic        ret_valid;
  logic [31:0] ret_pc;
  logic [15:0] ret_sig;
  logic        ret_branch;
  logic        fault;
  logic [31:0] fault_pc;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        f;
    logic [31:0] pc;
    string       req;
  } exp_t;
  exp_t q[$];

  // reference model state
  logic [15:0] m_run;
  int          m_cnt;
  logic [31:0] m_start;
  logic        m_v   [64];
  logic [23:0] m_tag [64];
  logic [15:0] m_sig [64];

  trace_sig_checker i_trace_sig_checker (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_sig(ret_sig), .ret_branch(ret_branch), .fault(fault), .fault_pc(fault_pc)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic model_clear();
    m_run = '0; m_cnt = 0; m_start = '0;
    for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
  endtask

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic retire(input logic [31:0] pc, input logic [15:0] sig,
                        input logic br, input string req);
    logic [15:0] base, nsig;
    logic [31:0] spc;
    logic        cl;
    int          ix;
    exp_t        e;
    @(negedge clk);
    ret_valid = 1'b1; ret_pc = pc; ret_sig = sig; ret_branch = br;
    base = (m_cnt == 0) ? 16'h0 : m_run;
    nsig = {base[14:0], base[15]} ^ sig;
    spc  = (m_cnt == 0) ? pc : m_start;
    cl   = br || (m_cnt == 15);
    m_run = nsig; m_start = spc;
    m_cnt = cl ? 0 : m_cnt + 1;
    if (cl) begin
      ix = int'(spc[7:2]);
      e.f   = m_v[ix] && (m_tag[ix] == spc[31:8]) && (m_sig[ix] != nsig);
      e.pc  = spc;
      e.req = req;
      q.push_back(e);
      m_v[ix] = 1'b1; m_tag[ix] = spc[31:8]; m_sig[ix] = nsig;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ret_valid = 1'b0; ret_branch = 1'b0;
    end
  endtask

  // monitor: compare results after each active edge
  always begin
    @(posedge clk);
    #5;
    if (rst_n) begin
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(fault == e.f, e.req, "fault", 32'(fault), 32'(e.f));
        if (e.f) check(fault_pc == e.pc, e.req, "fault_pc", fault_pc, e.pc);
      end else if (fault) begin
        check(1'b0, "R6", "unexpected fault", 32'(fault), 32'h0);
      end
    end
  end

  // run of three instructions ending with a branch
  task automatic short_trace(input logic [31:0] pc, input logic [15:0] s2, input string req);
    retire(pc,       16'h1234, 1'b0, req);
    retire(pc + 4,   s2,       1'b0, req);
    retire(pc + 8,   16'h00F0, 1'b1, req);
  endtask

  task automatic long_trace(input logic [15:0] s17, input string req);
    for (int i = 0; i < 21; i++)
      retire(32'h400 + 32'(i * 4), (i == 16) ? s17 : 16'(i * 16'h0111 + 3), i == 20, req);
  endtask

  initial begin
    rst_n = 1'b0; ret_valid = 1'b0; ret_pc = '0; ret_sig = '0; ret_branch = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    check(fault == 1'b0, "R9", "fault in reset", 32'(fault), 32'h0);
    rst_n = 1'b1;
    idle(2);
    check(fault == 1'b0, "R9", "fault after reset", 32'(fault), 32'h0);

    short_trace(32'h100, 16'hAAAA, "R4");   // miss installs
    short_trace(32'h100, 16'hAAAA, "R5");   // match
    short_trace(32'h100, 16'hAAAB, "R6");   // mismatch -> fault
    short_trace(32'h100, 16'hAAAB, "R7");   // overwritten, silent

    long_trace(16'h5555, "R3");             // install two traces
    long_trace(16'h5556, "R3");             // fault at start 0x440

    short_trace(32'h200, 16'hAAAB, "R8");   // same index as 0x100, other tag
    short_trace(32'h100, 16'h0001, "R8");   // 0x100 replaced: miss

    // R10: gaps inside a trace change nothing
    retire(32'h800, 16'h0011, 1'b0, "R10");
    retire(32'h804, 16'h0022, 1'b1, "R10");
    retire(32'h800, 16'h0011, 1'b0, "R10");
    idle(3);
    retire(32'h804, 16'h0022, 1'b1, "R10");
    idle(2);
    retire(32'h800, 16'h0011, 1'b0, "R10");
    idle(2);
    retire(32'h804, 16'h0023, 1'b1, "R10");

    // R1: 1,0 and 0,2 fold to the same value; 2,0 does not
    retire(32'hC00, 16'h0001, 1'b0, "R1");
    retire(32'hC04, 16'h0000, 1'b1, "R1");
    retire(32'hC00, 16'h0000, 1'b0, "R1");
    retire(32'hC04, 16'h0002, 1'b1, "R1");
    retire(32'hC00, 16'h0002, 1'b0, "R1");
    retire(32'hC04, 16'h0000, 1'b1, "R1");

    // R2: single-instruction branch traces back to back
    retire(32'hE00, 16'h0100, 1'b1, "R2");
    retire(32'hE10, 16'h0200, 1'b1, "R2");
    retire(32'hE00, 16'h0101, 1'b1, "R2");
    retire(32'hE10, 16'h0201, 1'b1, "R2");
    idle(3);

    // R9: reset forgets stored signatures
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    check(fault == 1'b0, "R9", "fault during reset", 32'(fault), 32'h0);
    rst_n = 1'b1;
    short_trace(32'h100, 16'h7777, "R9");
    idle(3);
    check(q.size() == 0, "R6", "pending results", 32'(q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule